// File: doc/BRIEF.md
# Fine-Adjust 8-bit Interval Timer

This block is an 8-bit down-counting interval timer. It counts on cycles where the count-clock enable is high, reloads from a programmable reload value, and marks each underflow with a one-cycle pulse. It also toggles a divided output clock on each underflow. The base period is reload+1 enabled ticks.

A 4-bit trim setting N adds one extra tick to N out of every 16 consecutive underflow periods. This lets the average output rate be set in steps of one sixteenth of a tick, for example to correct a baud-rate error. When a period is stretched, the counter stays at zero for one more enabled tick before it reloads, so the underflow pulse and the output clock edge both arrive one tick later.

Software drives the timer through a small register port. It can start and stop the timer, pick one-shot or repeat operation, force a reload, and read back the live counter value.

Top module: `fine_timer8`

## Requirements
- R1: Read address 0 returns the counter in bits [7:0] with bits [15:8] zero; the counter resets to 0xFF; a write to address 0 leaves the counter unchanged.
- R2: The counter decrements by one on each clock where cnt_en=1 and the run bit is 1. When cnt_en=0 or run=0 it holds its value.
- R3: An enabled tick with the counter at 0 and no stretch due reloads the counter from the reload register (address 2, bits [7:0]). uflow is then 1 for exactly the next clock. The unstretched period is reload+1 ticks.
- R4: clk_out inverts in the same cycle as each uflow pulse and is otherwise steady.
- R5: Trim N (address 1, bits [11:8]) stretches N of each 16 consecutive underflow periods, numbered 1 to 16. The positions are added in this order as N grows: 16, 8, 12, 4, 14, 6, 10, 2, 15, 7, 11, 3, 13, 5, 9. Position 1 is never stretched.
- R6: A stretched period lasts reload+2 ticks. The counter stays at 0 for one extra enabled tick, and uflow and clk_out follow one tick later.
- R7: The frame position advances by one on each underflow and returns to 1 after position 16.
- R8: Address 1 bit 4 = 1 selects one-shot mode, which clears the run bit on the first underflow. Bit 4 = 0 keeps the timer running.
- R9: Writing 1 to address 1 bit 1 reloads the counter, returns the frame to position 1 and cancels any pending stretch. This write overrides a tick in the same cycle. Writing 0 to that bit does nothing.
- R10: Address 1 reads run in bit 0, mode in bit 4 and trim in bits [11:8]; all other bits, including bit 1, read 0. rd_data is registered and shows the state of the previous clock's rd_addr.
- R11: Synchronous reset sets counter and reload to 0xFF, clears run, mode and trim, sets clk_out=0 and uflow=0, and returns the frame to position 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable, one tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| uflow | output | 1 | One-cycle underflow pulse |
| clk_out | output | 1 | Divided output clock, toggles on underflow |

## Verification
Register writes take effect on the next rising edge. rd_data appears one clock after rd_addr, and uflow and clk_out change on the edge that follows the enabled tick at zero. The bench drives inputs on falling edges and keeps a behavioural model that it advances on rising edges with the values in place before the edge. Every output is compared on the following falling edge, so each result is checked in the cycle it becomes due. Period-length checks count falling edges between underflow pulses, starting from the edge after a clearing write. This gives reload+1 or reload+2 for each frame position.

// File: rtl/ft8_pkg.sv
package ft8_pkg;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_TRIM_W = 4;
  localparam int unsigned DEF_REG_W  = 16;
  localparam int unsigned DEF_ADDR_W = 2;

  // register map
  localparam logic [DEF_ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [DEF_ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [DEF_ADDR_W-1:0] A_RELOAD = 2'd2;

  // control field positions
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_CLR  = 1;
  localparam int unsigned B_ONE  = 4;
  localparam int unsigned B_TRIM = 8;
endpackage

// File: rtl/ft8_regs.sv
module ft8_regs
  import ft8_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned TRIM_W = DEF_TRIM_W,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output logic              run,
  output logic              one_shot,
  output logic [TRIM_W-1:0] trim,
  output logic [CNT_W-1:0]  reload,
  output logic              sw_clr,
  output logic [REG_W-1:0]  rd_data
);
  logic             ctrl_wr;
  logic             rel_wr;
  logic [REG_W-1:0] rd_mux;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign rel_wr  = wr_en && (wr_addr == A_RELOAD);
  assign sw_clr  = ctrl_wr && wr_data[B_CLR];

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_COUNT:  rd_mux[CNT_W-1:0] = count;
      A_CTRL: begin
        rd_mux[B_RUN]              = run;
        rd_mux[B_ONE]              = one_shot;
        rd_mux[B_TRIM +: TRIM_W]   = trim;
      end
      A_RELOAD: rd_mux[CNT_W-1:0] = reload;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      one_shot <= 1'b0;
      trim     <= '0;
      reload   <= '1;
      rd_data  <= '0;
    end else begin
      if (ctrl_wr) begin
        run      <= wr_data[B_RUN];
        one_shot <= wr_data[B_ONE];
        trim     <= wr_data[B_TRIM +: TRIM_W];
      end else if (wrap && one_shot) begin
        run <= 1'b0;
      end
      if (rel_wr) reload <= wr_data[CNT_W-1:0];
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/ft8_trim.sv
module ft8_trim
  import ft8_pkg::*;
#(
  parameter int unsigned TRIM_W = DEF_TRIM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_clr,
  input  logic              wrap,
  input  logic [TRIM_W-1:0] trim,
  output logic              stretch_due
);
  // pos = frame position - 1
  logic [TRIM_W-1:0] pos;
  logic [TRIM_W-1:0] from_end;
  logic [TRIM_W-1:0] rank;

  assign from_end = ~pos;

  // fill rank of a position is the bit-reversed distance from the frame end
  for (genvar i = 0; i < TRIM_W; i++) begin : g_rev
    assign rank[i] = from_end[TRIM_W-1-i];
  end

  assign stretch_due = (rank < trim);

  always_ff @(posedge clk) begin
    if (rst || sw_clr) pos <= '0;
    else if (wrap)     pos <= pos + 1'b1;
  end
endmodule

// File: rtl/ft8_core.sv
module ft8_core
  import ft8_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             run,
  input  logic             sw_clr,
  input  logic             stretch_due,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             uflow,
  output logic             clk_out
);
  logic tick;
  logic at_zero;
  logic held;

  assign tick    = cnt_en && run && !sw_clr;
  assign at_zero = (count == '0);
  assign wrap    = tick && at_zero && !(stretch_due && !held);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '1;
      held    <= 1'b0;
      uflow   <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      uflow <= wrap;
      if (wrap) clk_out <= ~clk_out;
      if (sw_clr) begin
        count <= reload;
        held  <= 1'b0;
      end else if (tick) begin
        if (!at_zero) begin
          count <= count - 1'b1;
        end else if (wrap) begin
          count <= reload;
          held  <= 1'b0;
        end else begin
          held <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fine_timer8.sv
module fine_timer8
  import ft8_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned TRIM_W = DEF_TRIM_W,
  parameter int unsigned REG_W  = DEF_REG_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              uflow,
  output logic              clk_out
);
  logic              run_q;
  logic              one_shot_q;
  logic [TRIM_W-1:0] trim_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  count_q;
  logic              sw_clr;
  logic              wrap;
  logic              stretch_due;

  ft8_regs #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .count(count_q), .wrap(wrap), .run(run_q),
    .one_shot(one_shot_q), .trim(trim_q), .reload(reload_q), .sw_clr(sw_clr),
    .rd_data(rd_data)
  );

  ft8_trim #(.TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst(rst), .sw_clr(sw_clr), .wrap(wrap), .trim(trim_q),
    .stretch_due(stretch_due)
  );

  ft8_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .run(run_q), .sw_clr(sw_clr),
    .stretch_due(stretch_due), .reload(reload_q), .count(count_q),
    .wrap(wrap), .uflow(uflow), .clk_out(clk_out)
  );
endmodule

// File: rtl/ft8_checker.sv
module ft8_checker
  import ft8_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              run,
  input logic              one_shot,
  input logic              sw_clr,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              uflow,
  input logic              clk_out
);
  logic past_ok;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_UFLOW_QUALIFIED: assert property (@(posedge clk) disable iff (rst) past_ok && uflow |-> $past(cnt_en) && $past(run)); // R3
  AST_RELOAD_ON_UFLOW: assert property (@(posedge clk) disable iff (rst) past_ok && uflow |-> count == $past(reload)); // R3
  AST_UFLOW_FROM_ZERO: assert property (@(posedge clk) disable iff (rst) past_ok && uflow |-> $past(count) == '0); // R6
  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (rst) past_ok && uflow |-> clk_out != $past(clk_out)); // R4
  AST_CLK_STEADY: assert property (@(posedge clk) disable iff (rst) past_ok && !uflow |-> clk_out == $past(clk_out)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) past_ok && !$past(run) && !$past(sw_clr) |-> count == $past(count)); // R2
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst) past_ok && uflow && $past(one_shot) && !$past(ctrl_wr) |-> !run); // R8
  AST_CLEAR_RELOADS: assert property (@(posedge clk) disable iff (rst) past_ok && $past(sw_clr) |-> count == $past(reload) && !uflow); // R9
endmodule

bind fine_timer8 ft8_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .run(run_q), .one_shot(one_shot_q), .sw_clr(sw_clr), .count(count_q),
  .reload(reload_q), .uflow(uflow), .clk_out(clk_out)
);

// File: tb/test_fine_timer8.sv
`timescale 1ns/1ps
module test_fine_timer8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        uflow;
  logic        clk_out;

  always #2.5 clk = ~clk;

  fine_timer8 i_fine_timer8 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .uflow(uflow),
    .clk_out(clk_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;
  string tag = "R11";

  // behavioural reference state
  int m_cnt, m_rel, m_trim, m_pos;
  bit m_run, m_one, m_extra, e_uf, e_clk;
  int e_rd;

  function automatic bit is_delayed(int pos, int trim);
    int order [15] = '{16, 8, 12, 4, 14, 6, 10, 2, 15, 7, 11, 3, 13, 5, 9};
    for (int k = 0; k < trim; k++) if (order[k] == pos) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual %0d expected %0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit clr_wr;
    case (rd_addr)
      2'd0: e_rd = m_cnt;
      2'd1: e_rd = (m_trim << 8) | (int'(m_one) << 4) | int'(m_run);
      2'd2: e_rd = m_rel;
      default: e_rd = 0;
    endcase
    e_uf = 1'b0;
    if (rst) begin
      m_cnt = 255; m_rel = 255; m_trim = 0; m_pos = 1;
      m_run = 0; m_one = 0; m_extra = 0; e_clk = 0; e_rd = 0;
      model_on = 1'b1;
    end else begin
      clr_wr = wr_en && wr_addr == 2'd1 && wr_data[1];
      if (clr_wr) begin
        m_cnt = m_rel; m_pos = 1; m_extra = 0;
      end else if (cnt_en && m_run) begin
        if (m_cnt > 0) m_cnt--;
        else if (is_delayed(m_pos, m_trim) && !m_extra) m_extra = 1;
        else begin
          m_cnt = m_rel; m_extra = 0; e_uf = 1; e_clk = !e_clk;
          m_pos = (m_pos % 16) + 1;
          if (m_one) m_run = 0;
        end
      end
      if (wr_en && wr_addr == 2'd1) begin
        m_run = wr_data[0]; m_one = wr_data[4]; m_trim = wr_data[11:8];
      end
      if (wr_en && wr_addr == 2'd2) m_rel = wr_data[7:0];
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check(uflow === e_uf, "R3 uflow", uflow, e_uf);
      check(clk_out === e_clk, "R4 clk_out", clk_out, e_clk);
      if (rd_addr == 2'd1)
        check(rd_data === 16'(e_rd), "R10 control readback", rd_data, e_rd);
      else if (rd_addr == 2'd0)
        check(rd_data === 16'(e_rd), "R1 count readback", rd_data, e_rd);
      else
        check(rd_data === 16'(e_rd), "R3 reload readback", rd_data, e_rd);
    end
  end

  // rolling read address, sampled on the registered read port
  initial begin
    forever begin
      @(negedge clk);
      rd_addr <= rd_addr + 2'd1;
    end
  end

  task automatic write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_uflow(input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (uflow) n++;
    end
  endtask

  task automatic run_frame(input int rel, input int trim, input int periods);
    int len;
    int exp;
    write(2'd2, 16'(rel));
    cnt_en = 1'b1;
    write(2'd1, 16'h0003 | 16'(trim << 8));
    for (int p = 1; p <= periods; p++) begin
      len = 0;
      do begin
        @(negedge clk);
        len++;
      end while (!uflow && len < 1000);
      exp = rel + 1 + (is_delayed(((p - 1) % 16) + 1, trim) ? 1 : 0);
      check(len == exp, "R5 R6 R7 period length", len, exp);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R11";
    repeat (6) @(negedge clk);

    tag = "R1";
    write(2'd0, 16'h12AB);
    repeat (6) @(negedge clk);

    tag = "R2";
    write(2'd2, 16'd5);
    write(2'd1, 16'h0003);
    cnt_en = 1'b0;
    count_uflow(12, n);
    check(n == 0, "R2 no ticks without cnt_en", n, 0);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      cnt_en = c[0];
    end
    tag = "R2 R3 R4";
    cnt_en = 1'b1;
    count_uflow(24, n);
    check(n == 4, "R3 base period reload+1", n, 4);

    tag = "R5 R6 R7";
    run_frame(3, 0, 16);
    run_frame(3, 1, 16);
    run_frame(2, 3, 16);
    run_frame(4, 5, 32);
    run_frame(1, 10, 16);
    run_frame(2, 15, 32);

    tag = "R9";
    run_frame(3, 8, 7);
    run_frame(3, 8, 16);
    write(2'd1, 16'h0801);
    repeat (5) @(negedge clk);
    write(2'd1, 16'h0803);
    repeat (9) @(negedge clk);

    tag = "R8";
    write(2'd2, 16'd2);
    write(2'd1, 16'h0013);
    count_uflow(12, n);
    check(n == 1, "R8 one-shot single underflow", n, 1);
    write(2'd1, 16'h0003);
    count_uflow(12, n);
    check(n == 4, "R8 repeat mode keeps running", n, 4);

    tag = "R10";
    write(2'd1, 16'h0A11);
    repeat (8) @(negedge clk);
    write(2'd1, 16'h0000);
    repeat (8) @(negedge clk);

    tag = "R11";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule